// File: doc/BRIEF.md
# Serially Serviced Window Watchdog

This block supervises a host processor through a window watchdog that the host services by writing a dedicated period field over a serial control link. The serial shifter lives elsewhere. It hands this block a one-cycle strobe when chip select returns high at the end of a frame, together with a flag that says whether that frame wrote the watchdog period field and the period code carried by the frame. A separate timebase supplies a one-cycle tick that advances all window timing.

After reset release, and after every watchdog fault, the block opens a long open window of 256 ticks. Any trigger in that window is accepted. An accepted trigger starts a closed window. When the closed window ends, an open window follows. Each of these two windows lasts half of the period selected by the trigger's code. A trigger in the open window starts the next closed window at once. A trigger during the closed window is a fault. An open or long open window that runs out with no trigger is also a fault. A fault raises a one-cycle reset request and a one-cycle standby request, and it sets a sticky flag that the next serial access clears. While the system is in a low-power mode the watchdog is halted unless a keep-alive control holds it running.

Top module: `spi_window_wdt`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `rst_req`, `stby_req` and `wd_flag` are 0. Timing starts in the long open window with its tick count at zero.
- R2: If no trigger arrives, a fault occurs on the 256th tick after reset release or after the previous fault. A trigger at any point in the long open window is accepted.
- R3: A trigger is a cycle with `frame_end`=1 and `field_wr`=1. It acts on the clock edge that samples it.
- R4: An accepted trigger starts a closed window of 8<<`period_code` ticks (codes 0,1,2,3 give 8,16,32,64, so full periods are 16,32,64,128). A trigger before the last tick of the closed window has been counted is a fault. This includes a trigger on the edge of that last tick.
- R5: The open window follows and lasts another 8<<code ticks. A trigger in it is accepted, also on the edge that counts its last tick. With no trigger, a fault occurs on the last tick.
- R6: The period code takes effect only from the closed window started by the trigger that carries it. A code sent on a frame that is not a trigger has no effect.
- R7: A fault drives `rst_req` and `stby_req` high together for exactly one cycle, on the edge after the cycle that caused it. Timing then restarts in the long open window.
- R8: `wd_flag` is set by a fault and holds until a `frame_end` that does not itself cause a fault. When one frame both faults and clears, the set wins.
- R9: A frame with `frame_end`=1 and `field_wr`=0 clears `wd_flag`. It does not restart or alter the window timing.
- R10: With `lp_mode`=1 and `lp_keep`=0 the watchdog is halted in a fresh long open window: no faults, triggers ignored. Timing resumes from zero when it is re-enabled. With `lp_keep`=1 it keeps running in low-power mode.
- R11: Window time advances only on cycles with `tick`=1. Without ticks or frames, no fault occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe, one count per high cycle |
| frame_end | input | 1 | One-cycle strobe at chip-select deassertion |
| field_wr | input | 1 | The ending frame wrote the watchdog period field |
| period_code | input | 2 | Period selector carried by the frame |
| lp_mode | input | 1 | System is in a low-power mode |
| lp_keep | input | 1 | Keep watchdog running in low-power mode |
| rst_req | output | 1 | One-cycle watchdog reset request |
| stby_req | output | 1 | One-cycle request to enter standby |
| wd_flag | output | 1 | Sticky watchdog-fault flag |

## Verification
Two functions can meet in one cycle. The first case is the frame that triggers too early: the same `frame_end` both clears the flag as an access and sets it as a fault. The bench provokes it by triggering on exactly the edge that counts the last closed-window tick, and it expects `wd_flag` to read 1 alongside the reset pulse. The second case is a trigger on the edge where the open window expires. The bench expects the trigger to win, so no reset follows, and it then confirms that the next timeout lands a full new period later.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Window phase of the watchdog
    typedef enum logic [1:0] {
        WIN_LONG   = 2'd0,
        WIN_CLOSED = 2'd1,
        WIN_OPEN   = 2'd2
    } win_e;

    // Qualified frame events seen at chip-select deassertion
    typedef struct packed {
        logic trig;    // frame wrote the period field
        logic access;  // any frame ended
    } frame_ev_t;

    // A trigger is legal everywhere except the closed window
    function automatic logic trig_legal(win_e s);
        return s != WIN_CLOSED;
    endfunction

    // Running out of a window is a fault except for the closed window
    function automatic logic expiry_faults(win_e s);
        return s != WIN_CLOSED;
    endfunction

    // Phase entered when the closed window runs out
    function automatic win_e after_closed();
        return WIN_OPEN;
    endfunction

endpackage

// File: rtl/wdt_frame_qual.sv
module wdt_frame_qual
    import wdt_pkg::*;
(
    input  logic      frame_end,
    input  logic      field_wr,
    input  logic      lp_mode,
    input  logic      lp_keep,
    output frame_ev_t ev,
    output logic      active
);

    always_comb begin
        ev.access = frame_end;
        ev.trig   = frame_end & field_wr;
        active    = ~lp_mode | lp_keep;
    end

endmodule

// File: rtl/wdt_window_timer.sv
module wdt_window_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit_m1,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    // Expiry: the tick that counts the last unit of the current window
    assign expire = tick & (cnt_q == limit_m1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= expire ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_window_ctrl.sv
module wdt_window_ctrl
    import wdt_pkg::*;
#(
    parameter int CODE_W     = 2,
    parameter int HALF_BASE  = 8,
    parameter int LONG_TICKS = 256,
    parameter int CNT_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  frame_ev_t         ev,
    input  logic [CODE_W-1:0] code,
    input  logic              expire,
    output logic [CNT_W-1:0]  limit_m1,
    output logic              cnt_clear,
    output logic              fault
);

    localparam logic [CNT_W-1:0] LONG_M1 = CNT_W'(LONG_TICKS - 1);
    localparam logic [CNT_W-1:0] BASE_M1 = CNT_W'(HALF_BASE - 1);

    win_e             state_q, state_d;
    logic [CNT_W-1:0] half_q, half_d;
    logic [CNT_W-1:0] half_new;

    // Half-period length (minus one) selected by the incoming code
    assign half_new = CNT_W'((HALF_BASE << code) - 1);

    always_comb begin
        state_d   = state_q;
        half_d    = half_q;
        cnt_clear = 1'b0;
        fault     = 1'b0;
        if (!active) begin
            state_d   = WIN_LONG;
            cnt_clear = 1'b1;
        end else if (ev.trig) begin
            if (trig_legal(state_q)) begin
                state_d   = WIN_CLOSED;
                half_d    = half_new;
                cnt_clear = 1'b1;
            end else begin
                fault = 1'b1;
            end
        end else if (expire) begin
            if (expiry_faults(state_q)) begin
                fault = 1'b1;
            end else begin
                state_d = after_closed();
            end
        end
        if (fault) begin
            state_d   = WIN_LONG;
            cnt_clear = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WIN_LONG;
            half_q  <= BASE_M1;
        end else begin
            state_q <= state_d;
            half_q  <= half_d;
        end
    end

    assign limit_m1 = (state_q == WIN_LONG) ? LONG_M1 : half_q;

endmodule

// File: rtl/wdt_fault_out.sv
module wdt_fault_out (
    input  logic clk,
    input  logic rst,
    input  logic fault,
    input  logic access,
    output logic rst_req,
    output logic stby_req,
    output logic wd_flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req  <= 1'b0;
            stby_req <= 1'b0;
            wd_flag  <= 1'b0;
        end else begin
            rst_req  <= fault;
            stby_req <= fault;
            if (fault) begin
                wd_flag <= 1'b1;
            end else if (access) begin
                wd_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/spi_window_wdt.sv
module spi_window_wdt
    import wdt_pkg::*;
#(
    parameter int CODE_W     = 2,
    parameter int HALF_BASE  = 8,
    parameter int LONG_TICKS = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              frame_end,
    input  logic              field_wr,
    input  logic [CODE_W-1:0] period_code,
    input  logic              lp_mode,
    input  logic              lp_keep,
    output logic              rst_req,
    output logic              stby_req,
    output logic              wd_flag
);

    localparam int MAX_HALF = HALF_BASE << ((1 << CODE_W) - 1);
    localparam int MAX_WIN  = (LONG_TICKS > MAX_HALF) ? LONG_TICKS : MAX_HALF;
    localparam int CNT_W    = $clog2(MAX_WIN);

    frame_ev_t        ev;
    logic             active;
    logic             expire;
    logic             cnt_clear;
    logic             fault;
    logic [CNT_W-1:0] limit_m1;

    wdt_frame_qual u_qual (
        .frame_end (frame_end),
        .field_wr  (field_wr),
        .lp_mode   (lp_mode),
        .lp_keep   (lp_keep),
        .ev        (ev),
        .active    (active)
    );

    wdt_window_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .clear    (cnt_clear),
        .limit_m1 (limit_m1),
        .expire   (expire)
    );

    wdt_window_ctrl #(
        .CODE_W     (CODE_W),
        .HALF_BASE  (HALF_BASE),
        .LONG_TICKS (LONG_TICKS),
        .CNT_W      (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .ev        (ev),
        .code      (period_code),
        .expire    (expire),
        .limit_m1  (limit_m1),
        .cnt_clear (cnt_clear),
        .fault     (fault)
    );

    wdt_fault_out u_out (
        .clk      (clk),
        .rst      (rst),
        .fault    (fault),
        .access   (ev.access),
        .rst_req  (rst_req),
        .stby_req (stby_req),
        .wd_flag  (wd_flag)
    );

endmodule

// File: rtl/spi_window_wdt_chk.sv
module spi_window_wdt_chk (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic frame_end,
    input logic field_wr,
    input logic lp_mode,
    input logic lp_keep,
    input logic rst_req,
    input logic stby_req,
    input logic wd_flag
);

    // R7
    rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R7
    stby_pair_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req == stby_req);

    // R8
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wd_flag) |-> rst_req);

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wd_flag && !frame_end) |=> wd_flag);

    // R9
    access_clear_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (wd_flag == rst_req));

    // R9
    plain_access_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !field_wr && !tick) |=> !rst_req);

    // R10
    halted_chk: assert property (@(posedge clk) disable iff (rst)
        (lp_mode && !lp_keep) |=> !rst_req);

    // R11
    quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !frame_end) |=> !rst_req);

endmodule

bind spi_window_wdt spi_window_wdt_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .frame_end (frame_end),
    .field_wr  (field_wr),
    .lp_mode   (lp_mode),
    .lp_keep   (lp_keep),
    .rst_req   (rst_req),
    .stby_req  (stby_req),
    .wd_flag   (wd_flag)
);

// File: tb/spi_window_wdt_bench.sv
module spi_window_wdt_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       frame_end = 1'b0;
    logic       field_wr = 1'b0;
    logic [1:0] period_code = 2'd0;
    logic       lp_mode = 1'b0;
    logic       lp_keep = 1'b0;
    logic       rst_req, stby_req, wd_flag;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_window_wdt u_spi_window_wdt (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .frame_end   (frame_end),
        .field_wr    (field_wr),
        .period_code (period_code),
        .lp_mode     (lp_mode),
        .lp_keep     (lp_keep),
        .rst_req     (rst_req),
        .stby_req    (stby_req),
        .wd_flag     (wd_flag)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // advance n clock edges, return just after the falling edge
    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    // one frame end on the next edge
    task automatic frame(logic wr, logic [1:0] code);
        frame_end   = 1'b1;
        field_wr    = wr;
        period_code = code;
        @(posedge clk);
        @(negedge clk);
        frame_end = 1'b0;
        field_wr  = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick = 1'b1;
        lp_mode = 1'b0;
        lp_keep = 1'b0;
        idle(2);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle(2);
        chk("R1", "rst_req in reset", rst_req, 1'b0);
        chk("R1", "wd_flag in reset", wd_flag, 1'b0);
        rst = 1'b0;
        idle(1);
        chk("R1", "rst_req after release", rst_req, 1'b0);
        chk("R1", "stby_req after release", stby_req, 1'b0);
        chk("R1", "wd_flag after release", wd_flag, 1'b0);
    endtask

    task automatic t_long_open();
        do_reset();
        idle(255);
        chk("R2", "no fault at tick 255", rst_req, 1'b0);
        idle(1);
        chk("R2", "fault at tick 256", rst_req, 1'b1);
        chk("R7", "standby with fault", stby_req, 1'b1);
        chk("R8", "flag set by fault", wd_flag, 1'b1);
        idle(1);
        chk("R7", "reset pulse ends", rst_req, 1'b0);
        chk("R7", "standby pulse ends", stby_req, 1'b0);
        chk("R8", "flag held", wd_flag, 1'b1);
        idle(254);
        chk("R7", "second long window not yet out", rst_req, 1'b0);
        idle(1);
        chk("R7", "second long window times out", rst_req, 1'b1);
    endtask

    // continues from a fault edge with the flag set
    task automatic t_plain_access();
        frame(1'b0, 2'd3);
        chk("R9", "plain access clears flag", wd_flag, 1'b0);
        chk("R9", "plain access no fault", rst_req, 1'b0);
        idle(254);
        chk("R9", "timing not restarted (before)", rst_req, 1'b0);
        idle(1);
        chk("R9", "timing not restarted (timeout)", rst_req, 1'b1);
    endtask

    task automatic t_early_trigger();
        do_reset();
        idle(10);
        frame(1'b1, 2'd0);
        chk("R2", "trigger accepted in long window", rst_req, 1'b0);
        idle(7);
        frame(1'b1, 2'd0);
        chk("R4", "trigger on last closed tick faults", rst_req, 1'b1);
        chk("R8", "set wins over access clear", wd_flag, 1'b1);
    endtask

    task automatic t_open_edges();
        do_reset();
        frame(1'b1, 2'd1);
        idle(16);
        frame(1'b1, 2'd1);
        chk("R5", "trigger first open cycle accepted", rst_req, 1'b0);
        chk("R3", "trigger leaves flag clear", wd_flag, 1'b0);
        idle(31);
        frame(1'b1, 2'd1);
        chk("R5", "trigger on last open tick accepted", rst_req, 1'b0);
        idle(31);
        chk("R5", "open window not yet out", rst_req, 1'b0);
        idle(1);
        chk("R5", "open window timeout", rst_req, 1'b1);
    endtask

    task automatic t_code_latch();
        do_reset();
        frame(1'b1, 2'd3);
        idle(40);
        frame(1'b0, 2'd0);
        idle(86);
        chk("R6", "code 3 period not yet out", rst_req, 1'b0);
        idle(1);
        chk("R6", "code 3 period of 128 ticks", rst_req, 1'b1);
        frame(1'b1, 2'd3);
        idle(64);
        frame(1'b1, 2'd0);
        chk("R6", "trigger after half 64 accepted", rst_req, 1'b0);
        idle(7);
        frame(1'b1, 2'd0);
        chk("R6", "new code 0 in effect", rst_req, 1'b1);
    endtask

    task automatic t_low_power();
        do_reset();
        lp_mode = 1'b1;
        idle(100);
        frame(1'b1, 2'd0);
        idle(200);
        chk("R10", "halted: no fault", rst_req, 1'b0);
        lp_mode = 1'b0;
        idle(255);
        chk("R10", "fresh long window after wake", rst_req, 1'b0);
        idle(1);
        chk("R10", "long window after wake times out", rst_req, 1'b1);
        do_reset();
        lp_mode = 1'b1;
        lp_keep = 1'b1;
        idle(255);
        chk("R10", "kept alive: not yet out", rst_req, 1'b0);
        idle(1);
        chk("R10", "kept alive: times out", rst_req, 1'b1);
        lp_mode = 1'b0;
        lp_keep = 1'b0;
    endtask

    task automatic t_tick_gate();
        do_reset();
        tick = 1'b0;
        idle(400);
        chk("R11", "no ticks: no fault", rst_req, 1'b0);
        tick = 1'b1;
        idle(255);
        chk("R11", "count starts with ticks", rst_req, 1'b0);
        idle(1);
        chk("R11", "timeout after 256 ticks", rst_req, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_long_open();
        t_plain_access();
        t_early_trigger();
        t_open_edges();
        t_code_latch();
        t_low_power();
        t_tick_gate();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule